// File: doc/BRIEF.md
# Multi-Channel Down-Counter Timer Register Block

This block places two or three independent down-counting timer channels behind a single byte-addressed register window. A bus master writes the shared run-control register to start or stop each channel. It can also program a shared output-mode bit. Each channel has its own reload, count and control words. Every channel drives its own interrupt line, and the lines are never merged.

Build-time parameters set the number of channels and whether the output-mode register exists. Only the last channel of a three-channel build holds the capture word and the capture-mode field. Any access that misses the window map, is not word aligned, or tries to start a channel that does not exist is rejected. A rejected access raises a one-cycle error pulse, and a rejected read returns zero. Read data is registered and appears in the cycle after the read strobe.

Top module: `tmu_unit`

## Requirements
- R1: After reset the run-control register, the output-mode bit, every control word and the capture word read 0. Every reload word and count word reads 0xFFFFFFFF, and all interrupt lines are low.
- R2: Offset 0x00 holds the output-mode bit. A write keeps only data bit 0, a read returns it in bit 0 with the other bits 0, and `outctl_o` follows it. When `HAS_OUTCTL` is 0, offset 0x00 is an illegal address.
- R3: Offset 0x04 is the run-control register. Bit n runs channel n while set and halts it while clear. A read returns the NCH stored bits and 0 in every higher bit. Data bits at NCH and above are dropped on a write.
- R4: Channel n occupies the words at 0x08 + 12·n: +0 reload, +4 count, +8 control. Channel 2 adds a capture word at +12 (offset 0x2C). Each access reaches only the addressed word.
- R5: A running channel ticks once every D cycles of `clk`. D is 4, 16, 64 or 256 for control bits [2:0] = 0..3, and 1024 for values 4 to 7. A tick decrements a nonzero count by one. A tick at count 0 loads the reload value and sets the underflow flag.
- R6: A halted channel keeps its count. Running it again resumes from that value, with the first tick D cycles after the run bit is set.
- R7: An access is illegal if it is not word aligned, lies outside every mapped word, or is a rejected run-control write. An illegal write changes nothing, and an illegal read returns 0. Either one makes `err_o` high for exactly the cycle after the strobe. A legal access leaves `err_o` low.
- R8: A read returns its data on `rdata_o` in the cycle after the cycle in which `rd_i` is sampled high.
- R9: Control bits [7:6] (capture mode) are stored only in channel 2 and read 0 in the other channels. The capture word at 0x2C exists only in a three-channel build.
- R10: Control bit 8 is the underflow flag and bit 5 is the interrupt enable. `irq_o[n]` is high exactly when both are set for channel n. Writing 0 to bit 8 clears the flag, and writing 1 to it leaves the flag unchanged.
- R11: In a two-channel build (NCH = 2), every offset from 0x20 upward is illegal. So is a run-control write with data bit 2 set, and that write leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, one cycle per access |
| addr_i | input | ADDR_W | Byte offset within the window |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| err_o | output | 1 | One-cycle pulse for an illegal access |
| outctl_o | output | 1 | Stored output-mode bit |
| irq_o | output | NCH | Per-channel interrupt lines |

## Verification
The assertions assume that the master never raises `wr_i` and `rd_i` together, and that `rst_n` stays low across at least one clock edge with both strobes low. The bench meets this by changing the strobes only on the falling edge, issuing one access at a time, and holding the strobes low through reset. Count timing is checked through stop-then-read sequences spaced a known number of edges apart, so each expected count follows directly from the tick period.

// File: rtl/tmu_pkg.sv
package tmu_pkg;

  localparam int OFF_OUTCTL = 0;
  localparam int OFF_START  = 4;
  localparam int CH_FIRST   = 8;
  localparam int CH_STRIDE  = 12;
  localparam int CAPT_CH    = 2;
  localparam int MAX_DIV    = 1024;

  localparam int CTL_IE   = 5;
  localparam int CTL_CAPC = 6;
  localparam int CTL_FLAG = 8;

  typedef enum logic [1:0] {
    REG_CONST = 2'd0,
    REG_COUNT = 2'd1,
    REG_CTRL  = 2'd2,
    REG_CAPT  = 2'd3
  } chreg_e;

  function automatic int ch_base(int n);
    return CH_FIRST + CH_STRIDE * n;
  endfunction

  function automatic int ch_span(int n);
    return (n == CAPT_CH) ? CH_STRIDE + 4 : CH_STRIDE;
  endfunction

  function automatic int presc_div(logic [2:0] sel);
    if (sel >= 3'd4) return MAX_DIV;
    return 4 << (2 * int'(sel));
  endfunction

endpackage

// File: rtl/tmu_decode.sv
module tmu_decode
  import tmu_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NCH        = 3,
  parameter bit HAS_OUTCTL = 1'b1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_oc_o,
  output logic              hit_start_o,
  output logic [NCH-1:0]    hit_ch_o,
  output chreg_e            reg_o,
  output logic              illegal_o
);

  logic aligned;

  always_comb begin
    aligned     = (addr_i[1:0] == 2'b00);
    hit_oc_o    = HAS_OUTCTL && aligned && (addr_i == ADDR_W'(OFF_OUTCTL));
    hit_start_o = aligned && (addr_i == ADDR_W'(OFF_START));
    hit_ch_o    = '0;
    reg_o       = REG_CONST;
    for (int n = 0; n < NCH; n++) begin
      if (aligned && (int'(addr_i) >= ch_base(n)) &&
          (int'(addr_i) < ch_base(n) + ch_span(n))) begin
        hit_ch_o[n] = 1'b1;
        reg_o       = chreg_e'(2'((int'(addr_i) - ch_base(n)) >> 2));
      end
    end
    illegal_o = !(hit_oc_o || hit_start_o || (|hit_ch_o));
  end

endmodule

// File: rtl/tmu_channel.sv
module tmu_channel
  import tmu_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter bit HAS_CAPT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              wr_i,
  input  chreg_e            reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);

  localparam int PRE_W = $clog2(MAX_DIV);

  logic [DATA_W-1:0] konst_q, cnt_q, capt_q, ctl_view;
  logic [2:0]        sel_q;
  logic              ie_q, flag_q;
  logic [1:0]        capc_q;
  logic [PRE_W-1:0]  pre_q, pre_last;

  logic wr_konst, wr_cnt, wr_ctrl, wr_capt;
  logic tick, underflow;

  assign wr_konst  = wr_i && (reg_i == REG_CONST);
  assign wr_cnt    = wr_i && (reg_i == REG_COUNT);
  assign wr_ctrl   = wr_i && (reg_i == REG_CTRL);
  assign wr_capt   = wr_i && (reg_i == REG_CAPT);
  assign pre_last  = PRE_W'(presc_div(sel_q) - 1);
  assign tick      = run_i && (pre_q == pre_last);
  assign underflow = tick && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        pre_q <= '0;
    else if (!run_i || wr_ctrl || tick) pre_q <= '0;
    else                               pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '1;
    else if (wr_cnt)    cnt_q <= wdata_i;
    else if (underflow) cnt_q <= konst_q;
    else if (tick)      cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      konst_q <= '1;
      sel_q   <= '0;
      ie_q    <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      if (wr_konst) konst_q <= wdata_i;
      if (wr_ctrl) begin
        sel_q <= wdata_i[2:0];
        ie_q  <= wdata_i[CTL_IE];
      end
      flag_q <= ((wr_ctrl ? wdata_i[CTL_FLAG] : 1'b1) & flag_q) | underflow;
    end
  end

  generate
    if (HAS_CAPT) begin : g_capt
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          capt_q <= '0;
          capc_q <= '0;
        end else begin
          if (wr_capt) capt_q <= wdata_i;
          if (wr_ctrl) capc_q <= wdata_i[CTL_CAPC+1:CTL_CAPC];
        end
      end
    end else begin : g_nocapt
      assign capt_q = '0;
      assign capc_q = '0;
    end
  endgenerate

  always_comb begin
    ctl_view                        = '0;
    ctl_view[2:0]                   = sel_q;
    ctl_view[CTL_IE]                = ie_q;
    ctl_view[CTL_CAPC+1:CTL_CAPC]   = capc_q;
    ctl_view[CTL_FLAG]              = flag_q;
    case (reg_i)
      REG_CONST: rdata_o = konst_q;
      REG_COUNT: rdata_o = cnt_q;
      REG_CTRL:  rdata_o = ctl_view;
      default:   rdata_o = capt_q;
    endcase
  end

  assign irq_o = flag_q && ie_q;

  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !wr_cnt) |=> $stable(cnt_q));

  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !wr_cnt) |=> (cnt_q == $past(konst_q)) && flag_q);

  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (cnt_q != '0) && !wr_cnt) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/tmu_unit.sv
module tmu_unit
  import tmu_pkg::*;
#(
  parameter int NCH        = 3,
  parameter bit HAS_OUTCTL = 1'b1,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic              outctl_o,
  output logic [NCH-1:0]    irq_o
);

  logic           hit_oc, hit_start, acc_illegal;
  logic [NCH-1:0] hit_ch;
  chreg_e         reg_sel;

  logic           start_bad, wr_reject, wr_ok, start_wr;
  logic [NCH-1:0] start_q;
  logic           oc_q;
  logic [DATA_W-1:0] rd_view;
  logic [DATA_W-1:0] ch_rd [NCH];

  tmu_decode #(.ADDR_W(ADDR_W), .NCH(NCH), .HAS_OUTCTL(HAS_OUTCTL)) u_dec (
    .addr_i     (addr_i),
    .hit_oc_o   (hit_oc),
    .hit_start_o(hit_start),
    .hit_ch_o   (hit_ch),
    .reg_o      (reg_sel),
    .illegal_o  (acc_illegal)
  );

  assign start_bad = hit_start && (NCH < 3) && wdata_i[2];
  assign wr_reject = wr_i && (acc_illegal || start_bad);
  assign wr_ok     = wr_i && !wr_reject;
  assign start_wr  = wr_ok && hit_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        start_q <= '0;
    else if (start_wr) start_q <= wdata_i[NCH-1:0];
  end

  generate
    if (HAS_OUTCTL) begin : g_oc
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  oc_q <= 1'b0;
        else if (wr_ok && hit_oc)    oc_q <= wdata_i[0];
      end
    end else begin : g_nooc
      assign oc_q = 1'b0;
    end
  endgenerate

  assign outctl_o = oc_q;

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    tmu_channel #(.DATA_W(DATA_W), .HAS_CAPT(n == CAPT_CH)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (start_q[n]),
      .wr_i   (wr_ok && hit_ch[n]),
      .reg_i  (reg_sel),
      .wdata_i(wdata_i),
      .rdata_o(ch_rd[n]),
      .irq_o  (irq_o[n])
    );
  end

  always_comb begin
    rd_view = '0;
    if (hit_oc)    rd_view[0] = oc_q;
    if (hit_start) rd_view[NCH-1:0] = start_q;
    for (int n = 0; n < NCH; n++) begin
      if (hit_ch[n]) rd_view = ch_rd[n];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      if (rd_i) rdata_o <= acc_illegal ? '0 : rd_view;
      err_o <= (rd_i && acc_illegal) || wr_reject;
    end
  end

  assert_one_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_oc, hit_start, hit_ch}));

  assert_err_needs_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i || rd_i) |=> !err_o);

  assert_illegal_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && acc_illegal) |=> (rdata_o == '0) && err_o);

  assert_start_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !start_wr |=> $stable(start_q));

  if (NCH < 3) begin : g_two_chk
    assert_no_third_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && hit_start && wdata_i[2]) |=> err_o && $stable(start_q));
  end

endmodule

// File: tb/tmu_unit_test.sv
module tmu_unit_test;

  typedef struct {
    bit          dut;
    bit          chk;
    logic [31:0] data;
    bit          err;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0, dsel = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata3, rdata2;
  logic        err3, err2, oc3, oc2;
  logic [2:0]  irq3;
  logic [1:0]  irq2;
  logic        acc_q = 1'b0;
  logic        acc_dut = 1'b0;

  exp_t sb[$];
  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  tmu_unit #(.NCH(3), .HAS_OUTCTL(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .wr_i(wr && !dsel), .rd_i(rd && !dsel),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata3), .err_o(err3),
    .outctl_o(oc3), .irq_o(irq3));

  tmu_unit #(.NCH(2), .HAS_OUTCTL(1'b0)) uut2 (
    .clk(clk), .rst_n(rst_n), .wr_i(wr && dsel), .rd_i(rd && dsel),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata2), .err_o(err2),
    .outctl_o(oc2), .irq_o(irq2));

  always @(posedge clk) begin
    acc_q   <= wr || rd;
    acc_dut <= dsel;
  end

  // monitor: pops one expected item per completed access
  always @(negedge clk) begin
    if (acc_q && sb.size() > 0) begin
      exp_t e;
      logic [31:0] d;
      logic        er;
      e  = sb.pop_front();
      d  = e.dut ? rdata2 : rdata3;
      er = e.dut ? err2 : err3;
      compared++;
      if ((er !== e.err) || (e.chk && (d !== e.data))) begin
        mismatched++;
        $display("FAIL %s: data=%h err=%0b, expected data=%h err=%0b",
                 e.tag, d, er, e.data, e.err);
      end
    end
  end

  task automatic bus_wr(bit d, logic [7:0] a, logic [31:0] v, bit xerr, string tag);
    exp_t e;
    e.dut = d; e.chk = 1'b0; e.data = '0; e.err = xerr; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    dsel = d; addr = a; wdata = v; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(bit d, logic [7:0] a, logic [31:0] xdata, bit xerr, string tag);
    exp_t e;
    e.dut = d; e.chk = 1'b1; e.data = xdata; e.err = xerr; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    dsel = d; addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h, expected %h", tag, act, exp);
    end
  endtask

  // expected count after k edges of running at divider dv
  function automatic logic [31:0] after_ticks(logic [31:0] c0, int k, int dv);
    return c0 - 32'(k / dv);
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    mismatched++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    chk("R1 irq lines", {29'd0, irq3}, 32'd0);
    chk("R1 outctl pin", {31'd0, oc3}, 32'd0);
    bus_rd(0, 8'h04, 32'h0, 0, "R1 run-control reset");
    bus_rd(0, 8'h08, 32'hFFFF_FFFF, 0, "R1 reload0 reset");
    bus_rd(0, 8'h0C, 32'hFFFF_FFFF, 0, "R1 count0 reset");
    bus_rd(0, 8'h28, 32'h0, 0, "R1 control2 reset");
    bus_rd(0, 8'h2C, 32'h0, 0, "R1 capture reset");

    // R2 output-mode bit
    bus_wr(0, 8'h00, 32'hFFFF_FFFF, 0, "R2 write outctl");
    bus_rd(0, 8'h00, 32'h1, 0, "R2 outctl readback");
    chk("R2 outctl pin", {31'd0, oc3}, 32'd1);

    // R5 counting at divider 4, R4 map
    bus_wr(0, 8'h08, 32'd5, 0, "R4 reload0");
    bus_wr(0, 8'h0C, 32'd100, 0, "R4 count0");
    bus_wr(0, 8'h10, 32'd0, 0, "R4 control0");
    bus_wr(0, 8'h04, 32'h1, 0, "R3 run ch0");
    idle(38);
    bus_wr(0, 8'h04, 32'h0, 0, "R3 halt ch0");
    bus_rd(0, 8'h0C, after_ticks(100, 40, 4), 0, "R5 count0 after 40 edges");
    idle(20);
    bus_rd(0, 8'h0C, 32'd90, 0, "R6 count0 held while halted");
    bus_wr(0, 8'h04, 32'h1, 0, "R6 resume ch0");
    idle(10);
    bus_wr(0, 8'h04, 32'h0, 0, "R6 halt ch0 again");
    bus_rd(0, 8'h0C, after_ticks(90, 12, 4), 0, "R6 count0 resumed");

    // R5 underflow reload, R10 flag and interrupt on ch1
    bus_wr(0, 8'h14, 32'd2, 0, "R4 reload1");
    bus_wr(0, 8'h18, 32'd0, 0, "R4 count1");
    bus_wr(0, 8'h1C, 32'h20, 0, "R10 enable irq1");
    bus_wr(0, 8'h04, 32'h2, 0, "R3 run ch1");
    idle(6);
    bus_wr(0, 8'h04, 32'h0, 0, "R3 halt ch1");
    chk("R10 irq only ch1", {29'd0, irq3}, 32'b010);
    bus_rd(0, 8'h18, 32'd1, 0, "R5 reload then step");
    bus_rd(0, 8'h1C, 32'h120, 0, "R10 flag set in control1");
    bus_rd(0, 8'h08, 32'd5, 0, "R4 reload0 untouched");
    bus_wr(0, 8'h1C, 32'h120, 0, "R10 writing 1 keeps flag");
    chk("R10 irq kept", {29'd0, irq3}, 32'b010);
    bus_wr(0, 8'h1C, 32'h020, 0, "R10 clear flag");
    chk("R10 irq cleared", {29'd0, irq3}, 32'b000);
    bus_rd(0, 8'h1C, 32'h020, 0, "R10 control1 after clear");

    // R3 readback masks upper bits
    bus_wr(0, 8'h04, 32'hFFFF_FFF8, 0, "R3 upper bits only");
    bus_rd(0, 8'h04, 32'h0, 0, "R3 upper bits dropped");

    // R9 capture features
    bus_wr(0, 8'h2C, 32'h1234_5678, 0, "R9 capture write");
    bus_rd(0, 8'h2C, 32'h1234_5678, 0, "R9 capture readback");
    bus_wr(0, 8'h28, 32'hC0, 0, "R9 capture mode ch2");
    bus_rd(0, 8'h28, 32'hC0, 0, "R9 capture mode stored ch2");
    bus_wr(0, 8'h10, 32'hC0, 0, "R9 capture mode ch0");
    bus_rd(0, 8'h10, 32'h0, 0, "R9 capture mode dropped ch0");

    // R5 divider 16 on ch2
    bus_wr(0, 8'h24, 32'd50, 0, "R4 count2");
    bus_wr(0, 8'h28, 32'h1, 0, "R5 select divider 16");
    bus_wr(0, 8'h04, 32'h4, 0, "R3 run ch2");
    idle(30);
    bus_wr(0, 8'h04, 32'h0, 0, "R3 halt ch2");
    bus_rd(0, 8'h24, after_ticks(50, 32, 16), 0, "R5 count2 divider 16");

    // R7 illegal accesses
    bus_rd(0, 8'h30, 32'h0, 1, "R7 read past window");
    bus_rd(0, 8'h09, 32'h0, 1, "R7 unaligned read");
    bus_wr(0, 8'h0D, 32'h7, 1, "R7 unaligned write");
    bus_rd(0, 8'h0C, 32'd87, 0, "R7 count0 untouched by bad write");
    bus_wr(0, 8'h31, 32'h1, 1, "R7 write past window");
    bus_rd(0, 8'h04, 32'h0, 0, "R8 legal read after error");

    // R11 two-channel build
    bus_rd(1, 8'h20, 32'h0, 1, "R11 offset 0x20 illegal");
    bus_wr(1, 8'h2C, 32'h1, 1, "R11 capture write illegal");
    bus_rd(1, 8'h00, 32'h0, 1, "R2 no outctl in two-channel build");
    bus_wr(1, 8'h04, 32'h3, 0, "R3 run ch0 ch1 two-channel");
    bus_rd(1, 8'h04, 32'h3, 0, "R3 run readback two-channel");
    bus_wr(1, 8'h04, 32'h4, 1, "R11 run bit 2 rejected");
    bus_rd(1, 8'h04, 32'h3, 0, "R11 run-control unchanged");
    bus_wr(1, 8'h04, 32'h0, 0, "R3 halt two-channel");
    bus_rd(1, 8'h14, 32'hFFFF_FFFF, 0, "R4 reload1 two-channel");

    idle(4);
    finish_run();
  end

endmodule